// File: doc/BRIEF.md
# Flash Command Register Launch Interface

This block sits between a host register bus and the command engine of a flash memory controller. The host loads a command's parameter words one at a time. It first picks a slot with an index register and then writes the word through a shared window. It starts the command by writing 1 to a command-complete flag, which clears the flag. That write launches the engine only when both error flags are clear. The flag reads 0 while the command runs. When the engine finishes, it reports back and the flag returns to 1. The engine's result words then replace the parameter slots, so the host reads the results through the same window.

While a command is busy, the block drops window writes. A write to the index register at that time is refused and raises an access-error flag. A protection-violation flag records what the engine reports on completion. Both error flags are cleared by writing 1 to them, and either one blocks the next launch until it is cleared.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset the status register reads 1 in bit 0 (complete) and 0 in bit 1 (access error) and bit 2 (protection violation). The index reads 0, every slot reads 0 and `eng_start` is low.
- R2: Register codes on `reg_addr` are: 0 status, 1 index (bits 2:0), 2 parameter window, 3 reads zero. A window write stores `reg_wdata` into the slot chosen by the index, and a window read returns that slot. Index codes 6 and 7 read as zero through the window, and window writes at those codes are dropped.
- R3: A status write with bit 0 set, while the complete flag is 1 and both error flags are 0, takes effect at the next clock edge. After that edge the complete flag reads 0 and `eng_start` is high for exactly one cycle. `eng_params` carries slot k in bits [16k+15:16k].
- R4: While the complete flag is 0, window writes are ignored, and `eng_params` does not change until the engine reports done.
- R5: A launch write is refused when either error flag is already set before the write. In that case `eng_start` stays low and the complete flag stays 1.
- R6: An `eng_done` pulse while busy does three things at the next edge. It loads `eng_result` into the slots (same bit layout as in R3), sets the complete flag to 1, and sets the protection-violation flag if `eng_viol` is high.
- R7: A write to the index register while busy sets the access-error flag and leaves the index unchanged.
- R8: Writing 1 to status bit 1 or bit 2 clears that flag. Writing 0 to bit 0 has no effect, and writing 1 to bit 0 while busy has no effect.
- R9: An `eng_done` pulse while the complete flag is 1 is ignored. Slots and flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | SLOT_W | Write data |
| reg_rdata | output | SLOT_W | Read data for `reg_addr`, combinational |
| eng_start | output | 1 | One-cycle command launch pulse |
| eng_params | output | NUM_SLOTS*SLOT_W | Loaded parameter slots, flattened |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_result | input | NUM_SLOTS*SLOT_W | Result words, sampled with `eng_done` |
| eng_viol | input | 1 | Protection violation, sampled with `eng_done` |

## Verification
The bench builds the block with its default parameters: six 16-bit slots behind a 3-bit index. With this setting, index codes 6 and 7 have no slot behind them, so the bench can sweep all eight codes and reach the read-as-zero and drop-write paths. It runs four commands with engine latencies of 1, 4, 7 and 10 cycles. One command is probed with writes while busy. Another returns a violation, which exercises refusal of the next launch and the clear-by-writing-1 path.

// File: rtl/fcf_pkg.sv
package fcf_pkg;
   typedef enum logic [1:0] {
      REG_STAT  = 2'd0,
      REG_INDEX = 2'd1,
      REG_WIN   = 2'd2,
      REG_SPARE = 2'd3
   } fcf_reg_e;

   localparam int STAT_DONE_BIT = 0;
   localparam int STAT_ACC_BIT  = 1;
   localparam int STAT_PROT_BIT = 2;
   localparam int STAT_BITS     = 3;
endpackage

// File: rtl/fcf_ctrl.sv
module fcf_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic stat_wr,
   input  logic w_done,
   input  logic w_acc,
   input  logic w_prot,
   input  logic idx_wr,
   input  logic eng_done,
   input  logic eng_viol,
   output logic done_flag,
   output logic acc_err,
   output logic prot_err,
   output logic load_result,
   output logic eng_start
);
   logic launch;

   assign launch      = stat_wr & w_done & done_flag & ~acc_err & ~prot_err;
   assign load_result = eng_done & ~done_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_flag <= 1'b1;
         acc_err   <= 1'b0;
         prot_err  <= 1'b0;
         eng_start <= 1'b0;
      end else begin
         eng_start <= launch;
         if (launch)
            done_flag <= 1'b0;
         else if (load_result)
            done_flag <= 1'b1;
         acc_err  <= (acc_err & ~(stat_wr & w_acc)) | (idx_wr & ~done_flag);
         prot_err <= (prot_err & ~(stat_wr & w_prot)) | (load_result & eng_viol);
      end
   end
endmodule

// File: rtl/fcf_slot_file.sv
module fcf_slot_file #(
   parameter int SLOT_W    = 16,
   parameter int NUM_SLOTS = 6,
   parameter int IDX_W     = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        idx_wr,
   input  logic [IDX_W-1:0]            idx_val,
   input  logic                        win_wr,
   input  logic [SLOT_W-1:0]           win_data,
   input  logic                        load,
   input  logic [NUM_SLOTS*SLOT_W-1:0] load_data,
   output logic [IDX_W-1:0]            idx,
   output logic [SLOT_W-1:0]           win_rd,
   output logic [NUM_SLOTS*SLOT_W-1:0] slots_flat
);
   localparam int FLAT_W = NUM_SLOTS * SLOT_W;

   if (NUM_SLOTS < 1 || NUM_SLOTS > (1 << IDX_W)) begin : g_bad_slots
      $error("fcf_slot_file: NUM_SLOTS must fit the index range");
   end
   if (FLAT_W < SLOT_W) begin : g_bad_flat
      $error("fcf_slot_file: flattened width too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx <= '0;
      else if (idx_wr) idx <= idx_val;
   end

   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      logic [SLOT_W-1:0] word;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word <= '0;
         else if (load)
            word <= load_data[k*SLOT_W +: SLOT_W];
         else if (win_wr && idx == IDX_W'(k))
            word <= win_data;
      end
      assign slots_flat[k*SLOT_W +: SLOT_W] = word;
   end

   always_comb begin
      win_rd = '0;
      for (int k = 0; k < NUM_SLOTS; k++)
         if (idx == IDX_W'(k)) win_rd = slots_flat[k*SLOT_W +: SLOT_W];
   end
endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
   import fcf_pkg::*;
#(
   parameter int SLOT_W    = 16,
   parameter int NUM_SLOTS = 6,
   parameter int IDX_W     = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_wr,
   input  logic [1:0]                  reg_addr,
   input  logic [SLOT_W-1:0]           reg_wdata,
   output logic [SLOT_W-1:0]           reg_rdata,
   output logic                        eng_start,
   output logic [NUM_SLOTS*SLOT_W-1:0] eng_params,
   input  logic                        eng_done,
   input  logic [NUM_SLOTS*SLOT_W-1:0] eng_result,
   input  logic                        eng_viol
);
   if (SLOT_W < STAT_BITS || SLOT_W < IDX_W) begin : g_bad_width
      $error("flash_cmd_front: SLOT_W too narrow for status or index");
   end

   logic stat_wr, idx_req, win_req;
   logic done_flag, acc_err, prot_err, load_result;
   logic [IDX_W-1:0]  idx;
   logic [SLOT_W-1:0] win_rd;

   assign stat_wr = reg_wr && reg_addr == REG_STAT;
   assign idx_req = reg_wr && reg_addr == REG_INDEX;
   assign win_req = reg_wr && reg_addr == REG_WIN;

   fcf_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .stat_wr     (stat_wr),
      .w_done      (reg_wdata[STAT_DONE_BIT]),
      .w_acc       (reg_wdata[STAT_ACC_BIT]),
      .w_prot      (reg_wdata[STAT_PROT_BIT]),
      .idx_wr      (idx_req),
      .eng_done    (eng_done),
      .eng_viol    (eng_viol),
      .done_flag   (done_flag),
      .acc_err     (acc_err),
      .prot_err    (prot_err),
      .load_result (load_result),
      .eng_start   (eng_start)
   );

   fcf_slot_file #(
      .SLOT_W    (SLOT_W),
      .NUM_SLOTS (NUM_SLOTS),
      .IDX_W     (IDX_W)
   ) u_slots (
      .clk        (clk),
      .rst_n      (rst_n),
      .idx_wr     (idx_req & done_flag),
      .idx_val    (reg_wdata[IDX_W-1:0]),
      .win_wr     (win_req & done_flag),
      .win_data   (reg_wdata),
      .load       (load_result),
      .load_data  (eng_result),
      .idx        (idx),
      .win_rd     (win_rd),
      .slots_flat (eng_params)
   );

   always_comb begin
      unique case (reg_addr)
         REG_STAT:  reg_rdata = {{(SLOT_W-STAT_BITS){1'b0}}, prot_err, acc_err, done_flag};
         REG_INDEX: reg_rdata = {{(SLOT_W-IDX_W){1'b0}}, idx};
         REG_WIN:   reg_rdata = win_rd;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/fcf_checker.sv
module fcf_checker
   import fcf_pkg::*;
#(
   parameter int SLOT_W    = 16,
   parameter int NUM_SLOTS = 6
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        reg_wr,
   input logic [1:0]                  reg_addr,
   input logic                        wbit_done,
   input logic                        eng_start,
   input logic                        eng_done,
   input logic [NUM_SLOTS*SLOT_W-1:0] eng_params,
   input logic                        done_flag,
   input logic                        acc_err,
   input logic                        prot_err
);
   logic launch_req;
   assign launch_req = reg_wr && reg_addr == REG_STAT && wbit_done;

   assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_req && done_flag && !acc_err && !prot_err) |=> (eng_start && !done_flag));

   assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);

   assert_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_req && (acc_err || prot_err)) |=> !eng_start);

   assert_busy_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_flag && !eng_done) |=> $stable(eng_params));

   assert_done_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_flag && eng_done) |=> done_flag);

   assert_busy_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == REG_INDEX && !done_flag) |=> acc_err);

   assert_idle_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_flag && eng_done && !(reg_wr && reg_addr == REG_WIN)) |=> $stable(eng_params));
endmodule

bind flash_cmd_front fcf_checker #(
   .SLOT_W    (SLOT_W),
   .NUM_SLOTS (NUM_SLOTS)
) u_fcf_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .wbit_done  (reg_wdata[0]),
   .eng_start  (eng_start),
   .eng_done   (eng_done),
   .eng_params (eng_params),
   .done_flag  (done_flag),
   .acc_err    (acc_err),
   .prot_err   (prot_err)
);

// File: tb/test_flash_cmd_front.sv
module test_flash_cmd_front;
   localparam int CLK_PERIOD = 10;
   localparam int SW = 16;
   localparam int NS = 6;
   localparam int FW = SW * NS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_addr = 2'd0;
   logic [SW-1:0] reg_wdata = '0;
   logic [SW-1:0] reg_rdata;
   logic          eng_start;
   logic [FW-1:0] eng_params;
   logic          eng_done = 1'b0;
   logic [FW-1:0] eng_result = '0;
   logic          eng_viol = 1'b0;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_cmd_front #(.SLOT_W(SW), .NUM_SLOTS(NS), .IDX_W(3)) i_flash_cmd_front (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
      .eng_params(eng_params), .eng_done(eng_done), .eng_result(eng_result),
      .eng_viol(eng_viol)
   );

   task automatic chk(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [SW-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [SW-1:0] d);
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic respond(input int lat, input logic [FW-1:0] res, input logic viol);
      repeat (lat) @(negedge clk);
      eng_done = 1'b1; eng_result = res; eng_viol = viol;
      @(negedge clk);
      eng_done = 1'b0; eng_viol = 1'b0;
   endtask

   function automatic logic [SW-1:0] pval(input int c, input int k);
      return SW'(c * 16'h1000 + k * 16'h10 + 5);
   endfunction

   function automatic logic [SW-1:0] rval(input int c, input int k);
      return SW'(16'h8000 ^ (c << 8) ^ (k * 3));
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
   end

   initial begin
      logic [SW-1:0] d;
      logic [FW-1:0] exp_p;
      logic [SW-1:0] shadow [8];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, d); chk("R1 status", FW'(d), FW'(1));
      rd(2'd1, d); chk("R1 index", FW'(d), '0);
      chk("R1 start", FW'(eng_start), '0);
      chk("R1 params", eng_params, '0);
      rd(2'd3, d); chk("R2 spare code", FW'(d), '0);

      // R2 sweep all index codes
      for (int i = 0; i < 8; i++) begin
         wr(2'd1, SW'(i));
         wr(2'd2, SW'(16'hA000 + i * 16'h111));
         shadow[i] = (i < NS) ? SW'(16'hA000 + i * 16'h111) : '0;
         rd(2'd2, d); chk($sformatf("R2 window idx%0d", i), FW'(d), FW'(shadow[i]));
      end
      for (int i = 0; i < 8; i++) begin
         wr(2'd1, SW'(i));
         rd(2'd2, d); chk($sformatf("R2 readback idx%0d", i), FW'(d), FW'(shadow[i]));
      end

      // R8 writing 0 to complete bit
      wr(2'd0, 16'h0);
      rd(2'd0, d); chk("R8 zero write", FW'(d), FW'(1));

      for (int c = 0; c < 4; c++) begin
         exp_p = '0;
         for (int k = 0; k < NS; k++) begin
            wr(2'd1, SW'(k)); wr(2'd2, pval(c, k));
            exp_p[k*SW +: SW] = pval(c, k);
         end
         wr(2'd0, 16'h1);
         chk("R3 start pulse", FW'(eng_start), FW'(1));
         chk("R3 params", eng_params, exp_p);
         rd(2'd0, d);
         chk("R3 busy flag", FW'(d), '0);
         chk("R3 start single", FW'(eng_start), '0);
         if (c == 1) begin
            wr(2'd1, 16'h2);
            wr(2'd2, 16'hDEAD);
            chk("R4 busy window", eng_params, exp_p);
            rd(2'd0, d); chk("R7 access error", FW'(d), FW'(2));
            wr(2'd0, 16'h1);
            chk("R8 busy launch no start", FW'(eng_start), '0);
            rd(2'd0, d); chk("R8 busy launch flag", FW'(d), FW'(2));
         end
         exp_p = '0;
         for (int k = 0; k < NS; k++) exp_p[k*SW +: SW] = rval(c, k);
         respond(1 + 3 * c, exp_p, c == 2);
         rd(2'd0, d);
         chk("R6 status", FW'(d), FW'({c == 2, c == 1, 1'b1}));
         if (c == 1) begin
            rd(2'd1, d); chk("R7 index unchanged", FW'(d), FW'(NS - 1));
         end
         for (int k = 0; k < NS; k++) begin
            wr(2'd1, SW'(k));
            rd(2'd2, d); chk($sformatf("R6 result slot%0d", k), FW'(d), FW'(rval(c, k)));
         end
         if (c == 1 || c == 2) begin
            wr(2'd0, 16'h1);
            chk("R5 refused start", FW'(eng_start), '0);
            rd(2'd0, d); chk("R5 flag kept", FW'(d), FW'({c == 2, c == 1, 1'b1}));
            wr(2'd0, 16'h6);
            rd(2'd0, d); chk("R8 clear errors", FW'(d), FW'(1));
         end
      end

      // R9 done while idle
      exp_p = eng_params;
      respond(1, ~exp_p, 1'b1);
      chk("R9 params kept", eng_params, exp_p);
      rd(2'd0, d); chk("R9 status kept", FW'(d), FW'(1));
      wr(2'd1, 16'h4);
      rd(2'd2, d); chk("R9 slot kept", FW'(d), FW'(rval(3, 4)));

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule